// File: doc/BRIEF.md
# Overflow Alarm Timer

A 16-bit up-counter behind a small synchronous register port. Software picks a count source (off, every system clock, a fixed-rate tick pulse, or a second external tick pulse) and a power-of-two prescale. It then programs a start value and a limit. Each divided tick advances the counter. A tick taken while the counter equals the limit reloads the start value and raises a wrap flag. The flag drives the interrupt line when its enable bit is set. A period of N ticks from a start value of 0 therefore needs a limit of N-1.

The wrap flag is owned by a three-state machine:

- `FLG_CLEAR`: the flag is 0.
- `FLG_PEND`: the flag is 1 and software has not yet seen it.
- `FLG_SEEN`: the flag is 1 and the control word has been read while it was 1.

The machine moves between these states as follows:

- `CLEAR->PEND`, `SEEN->PEND` and `PEND->PEND`: taken on any wrap.
- `PEND->SEEN`: taken on a control read.
- `SEEN->CLEAR`: taken on a control write with bit 7 at 0 and no wrap in the same cycle.
- All other cases hold the state.

Top module: `ovf_alarm_timer`

## Requirements
- R1: After reset, the control word reads 0, the counter reads 0, the limit reads 0x0000FFFF, the start value reads 0 and `irq` is low.
- R2: Byte offsets are: control 0x00, counter 0x04, limit 0x08, start value 0x4C. The control word holds the prescale select in bits 2:0, the source select in bits 4:3, the interrupt enable in bit 6 and the wrap flag in bit 7. Bit 5, bits above 7, limit bits above 15 and any unmapped offset read 0.
- R3: The source select takes effect at the next system clock edge after the control write. Its values are: 0 stops counting and clears the divider; 1 counts every system clock; 2 counts `tick_fixed` pulses; 3 counts `tick_ext` pulses. A source that is not selected has no effect.
- R4: The selected source is divided by 2 to the power of the prescale select, so the counter advances once per 2^PS source pulses after the divider has been cleared.
- R5: The counter advances by one per divided tick while it differs from the limit, and holds otherwise.
- R6: A divided tick taken with the counter equal to the limit loads the start value and sets the wrap flag.
- R7: Any write to the counter offset loads the start value, whatever the write data.
- R8: The flag is cleared only by a control write with bit 7 at 0 after a control read that returned the flag at 1. A write of 1 to bit 7 has no effect, and so does a write of 0 that was not preceded by such a read.
- R9: A wrap in the same cycle as a clearing write leaves the flag at 1, and a fresh control read is then needed before a clear can take effect.
- R10: `irq` is high exactly while both the wrap flag and the interrupt enable are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tick_fixed | input | 1 | Fixed-rate one-cycle tick pulse (source 2) |
| tick_ext | input | 1 | Second one-cycle tick pulse (source 3) |
| irq | output | 1 | Wrap interrupt |

## Verification
A wrong flag state shows at once. An unarmed clear that succeeds, or a lost wrap in a race with a clear, changes `irq` one cycle after the offending write, and the bench watches `irq` after each such write. A divider phase or count error shows as a counter value that is off by one. This is read back through the counter offset within a few ticks of the fault. A wrong reload shows as a start-value mismatch on the first counter read after the wrap.

// File: rtl/alm_pkg.sv
`timescale 1ns/1ps
package alm_pkg;
    localparam int unsigned SEL_W = 3;
    localparam logic [7:0] OFF_CTRL  = 8'h00;
    localparam logic [7:0] OFF_COUNT = 8'h04;
    localparam logic [7:0] OFF_LIMIT = 8'h08;
    localparam logic [7:0] OFF_START = 8'h4C;
    localparam int unsigned FLAG_BIT = 7;

    typedef enum logic [1:0] {
        SRC_OFF   = 2'd0,
        SRC_SYS   = 2'd1,
        SRC_FIXED = 2'd2,
        SRC_EXT   = 2'd3
    } src_sel_e;

    typedef enum logic [1:0] {
        FLG_CLEAR = 2'd0,
        FLG_PEND  = 2'd1,
        FLG_SEEN  = 2'd2
    } flag_state_e;

    typedef struct packed {
        logic             ie;
        src_sel_e         src;
        logic [SEL_W-1:0] ps;
    } ctrl_t;
endpackage

// File: rtl/alm_prescaler.sv
`timescale 1ns/1ps
module alm_prescaler
    import alm_pkg::*;
#(
    parameter int unsigned PS_W = SEL_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  src_sel_e        src,
    input  logic [PS_W-1:0] ps,
    input  logic            tick_fixed,
    input  logic            tick_ext,
    output logic            cnt_tick
);
    localparam int unsigned DIV_W = (1 << PS_W) - 1;

    logic             src_pulse;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        unique case (src)
            SRC_OFF:   src_pulse = 1'b0;
            SRC_SYS:   src_pulse = 1'b1;
            SRC_FIXED: src_pulse = tick_fixed;
            SRC_EXT:   src_pulse = tick_ext;
            default:   src_pulse = 1'b0;
        endcase
    end

    assign mask     = ~({DIV_W{1'b1}} << ps);
    assign cnt_tick = src_pulse && ((div_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (!rst_n)                div_q <= '0;
        else if (src == SRC_OFF)   div_q <= '0;
        else if (src_pulse)        div_q <= div_q + DIV_W'(1);
    end

    assert_tick_needs_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_tick |-> (src != SRC_OFF));
endmodule

// File: rtl/alm_counter.sv
`timescale 1ns/1ps
module alm_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_tick,
    input  logic             load_start,
    input  logic [CNT_W-1:0] start_val,
    input  logic [CNT_W-1:0] limit_val,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    logic at_limit;

    assign at_limit = (count == limit_val);
    assign wrap     = cnt_tick && !load_start && at_limit;

    always_ff @(posedge clk) begin
        if (!rst_n)          count <= '0;
        else if (load_start) count <= start_val;
        else if (cnt_tick)   count <= at_limit ? start_val : count + CNT_W'(1);
    end

    assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_tick && !load_start) |=> $stable(count));
    assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == $past(start_val)));
    assert_cnt_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_start |=> (count == $past(start_val)));
endmodule

// File: rtl/alm_flag_fsm.sv
`timescale 1ns/1ps
module alm_flag_fsm
    import alm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic ctrl_rd,
    input  logic clr_wr,
    output logic flag
);
    flag_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAR: if (wrap) state_d = FLG_PEND;
            FLG_PEND:  if (!wrap && ctrl_rd) state_d = FLG_SEEN;
            FLG_SEEN: begin
                if (wrap)        state_d = FLG_PEND;
                else if (clr_wr) state_d = FLG_CLEAR;
            end
            default:   state_d = FLG_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        flag = (state_q != FLG_CLEAR);
    end

    assert_wrap_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag);
    assert_clear_needs_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(state_q == FLG_SEEN && clr_wr && !wrap));
    assert_race_disarms_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && clr_wr) |=> (flag && state_q == FLG_PEND));
endmodule

// File: rtl/ovf_alarm_timer.sv
`timescale 1ns/1ps
module ovf_alarm_timer
    import alm_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_fixed,
    input  logic              tick_ext,
    output logic              irq
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] limit_q, start_q, count;
    logic             hit_ctrl, hit_count, hit_limit, hit_start;
    logic             wr_en, rd_en, cnt_tick, wrap, flag;

    assign hit_ctrl  = (bus_addr == ADDR_W'(OFF_CTRL));
    assign hit_count = (bus_addr == ADDR_W'(OFF_COUNT));
    assign hit_limit = (bus_addr == ADDR_W'(OFF_LIMIT));
    assign hit_start = (bus_addr == ADDR_W'(OFF_START));
    assign wr_en     = bus_sel && bus_wr;
    assign rd_en     = bus_sel && !bus_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '{ie: 1'b0, src: SRC_OFF, ps: '0};
            limit_q <= {CNT_W{1'b1}};
            start_q <= '0;
        end else if (wr_en) begin
            if (hit_ctrl) begin
                ctrl_q.ps  <= bus_wdata[SEL_W-1:0];
                ctrl_q.src <= src_sel_e'(bus_wdata[SEL_W+1:SEL_W]);
                ctrl_q.ie  <= bus_wdata[6];
            end
            if (hit_limit) limit_q <= bus_wdata[CNT_W-1:0];
            if (hit_start) start_q <= bus_wdata[CNT_W-1:0];
        end
    end

    alm_prescaler #(.PS_W(SEL_W)) u_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .src        (ctrl_q.src),
        .ps         (ctrl_q.ps),
        .tick_fixed (tick_fixed),
        .tick_ext   (tick_ext),
        .cnt_tick   (cnt_tick)
    );

    alm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_tick   (cnt_tick),
        .load_start (wr_en && hit_count),
        .start_val  (start_q),
        .limit_val  (limit_q),
        .count      (count),
        .wrap       (wrap)
    );

    alm_flag_fsm u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap    (wrap),
        .ctrl_rd (rd_en && hit_ctrl),
        .clr_wr  (wr_en && hit_ctrl && !bus_wdata[FLAG_BIT]),
        .flag    (flag)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl)       bus_rdata = DATA_W'({flag, ctrl_q.ie, 1'b0, ctrl_q.src, ctrl_q.ps});
        else if (hit_count) bus_rdata = DATA_W'(count);
        else if (hit_limit) bus_rdata = DATA_W'(limit_q);
        else if (hit_start) bus_rdata = DATA_W'(start_q);
    end

    assign irq = flag && ctrl_q.ie;

    assert_irq_follows_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_ctrl && !bus_wdata[6]) |=> !irq);
endmodule

// File: tb/sim_ovf_alarm_timer.sv
`timescale 1ns/1ps
module sim_ovf_alarm_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_fixed = 1'b0, tick_ext = 1'b0;
    logic        irq;
    int          errors = 0, checks = 0, cyc = 0;
    bit          done = 1'b0;

    localparam logic [7:0] A_SC = 8'h00, A_CNT = 8'h04, A_MOD = 8'h08, A_INI = 8'h4C;

    always #5 clk = ~clk;

    ovf_alarm_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_fixed(tick_fixed), .tick_ext(tick_ext), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic pulse(input bit use_ext, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (use_ext) tick_ext = 1'b1; else tick_fixed = 1'b1;
            @(negedge clk);
            tick_ext = 1'b0; tick_fixed = 1'b0;
        end
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl", A_SC, 32'h0);
        rd_chk("R1 count", A_CNT, 32'h0);
        rd_chk("R1 limit", A_MOD, 32'h0000FFFF);
        rd_chk("R1 start", A_INI, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd_chk("R2 unmapped", 8'h10, 32'h0);
    endtask

    task automatic t_stopped;
        wr(A_MOD, 32'h3);
        pulse(1'b0, 5);
        rd_chk("R3 source off holds", A_CNT, 32'h0);
    endtask

    task automatic t_count_reload;
        wr(A_SC, 32'h10);
        pulse(1'b0, 3);
        rd_chk("R5 count to limit", A_CNT, 32'h3);
        rd_chk("R6 no flag before wrap", A_SC, 32'h10);
        pulse(1'b0, 1);
        rd_chk("R6 reload", A_CNT, 32'h0);
        rd_chk("R6 flag set", A_SC, 32'h90);
    endtask

    task automatic t_flag_clear;
        pulse(1'b0, 4);
        wr(A_SC, 32'h10);
        wr(A_SC, 32'h50);
        check("R8 unarmed clear ignored", {31'b0, irq}, 32'h1);
        rd_chk("R8 flag seen", A_SC, 32'hD0);
        wr(A_SC, 32'h50);
        check("R8 armed clear", {31'b0, irq}, 32'h0);
        wr(A_SC, 32'hD0);
        rd_chk("R8 write one ignored", A_SC, 32'h50);
        pulse(1'b0, 4);
        check("R10 irq raised", {31'b0, irq}, 32'h1);
        wr(A_SC, 32'h10);
        check("R10 irq masked", {31'b0, irq}, 32'h0);
        rd_chk("R10 flag kept", A_SC, 32'h90);
    endtask

    task automatic t_race;
        pulse(1'b0, 3);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_SC; bus_wdata = 32'h50;
        tick_fixed = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; tick_fixed = 1'b0;
        check("R9 wrap beats clear", {31'b0, irq}, 32'h1);
        wr(A_SC, 32'h50);
        check("R9 fresh read needed", {31'b0, irq}, 32'h1);
        rd_chk("R9 flag read", A_SC, 32'hD0);
        wr(A_SC, 32'h50);
        check("R9 clear after read", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_cnt_write;
        wr(A_INI, 32'h5);
        wr(A_MOD, 32'h7);
        wr(A_CNT, 32'h1234);
        rd_chk("R7 write loads start", A_CNT, 32'h5);
        pulse(1'b0, 2);
        rd_chk("R5 count from start", A_CNT, 32'h7);
        pulse(1'b0, 1);
        rd_chk("R6 reload nonzero start", A_CNT, 32'h5);
        rd_chk("R6 flag nonzero start", A_SC, 32'hD0);
    endtask

    task automatic t_prescale;
        wr(A_SC, 32'h02);
        wr(A_CNT, 32'h0);
        wr(A_SC, 32'h12);
        pulse(1'b0, 3);
        rd_chk("R4 divide hold", A_CNT, 32'h5);
        pulse(1'b0, 1);
        rd_chk("R4 divide first", A_CNT, 32'h6);
        pulse(1'b0, 4);
        rd_chk("R4 divide second", A_CNT, 32'h7);
    endtask

    task automatic t_sysclk;
        wr(A_MOD, 32'hFFFF);
        wr(A_INI, 32'h0);
        wr(A_SC, 32'h00);
        wr(A_CNT, 32'h0);
        wr(A_SC, 32'h08);
        repeat (10) @(negedge clk);
        wr(A_SC, 32'h00);
        rd_chk("R3 system clock source", A_CNT, 32'd12);
    endtask

    task automatic t_ext;
        wr(A_SC, 32'h18);
        pulse(1'b0, 3);
        rd_chk("R3 fixed ignored on ext", A_CNT, 32'd12);
        pulse(1'b1, 2);
        rd_chk("R3 ext source", A_CNT, 32'd14);
    endtask

    task automatic t_unused;
        wr(A_MOD, 32'hFFFFFFFF);
        rd_chk("R2 limit upper zero", A_MOD, 32'h0000FFFF);
        wr(A_SC, 32'hFFFFFF7F);
        rd_chk("R2 ctrl unused zero", A_SC, 32'h0000005F);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_stopped();
        t_count_reload();
        t_flag_clear();
        t_race();
        t_cnt_write();
        t_prescale();
        t_sysclk();
        t_ext();
        t_unused();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule